// File: doc/BRIEF.md
# Auto-Direction Open-Drain Line Multiplexer

This block connects one host-side group of open-drain card signal lines (a command line plus data lines) to one of several device-side ports. It has no direction-control input. Each line rests released, held high by an external weak pull-up. The block samples both ends of every line and records which end pulled low first. It then repeats that low onto the other end until the owner lets go. After both ends read high again, the line is free for a transfer in either direction.

A select input picks the device port. A new select takes effect only while every line is idle, so a transfer in progress is never cut off. Ports that are not selected are never driven, and their lows are ignored. Each pad appears as a separate input, output-enable and output-data signal, so all tristate buffers stay outside the block. The output data is always low, which means an enabled driver can only pull down. The card clock passes straight through.

Top module: `autodir_line_mux`

## Requirements
- R1: While reset is asserted and in the cycle after it, every output enable on both sides is 0.
- R2: When both ends of every line stay high, no output enable is asserted.
- R3: A low on host line L, held for three clock cycles, enables the driver of line L on the selected device port. The driver pulls low because its output data is 0. The host driver of line L stays off.
- R4: A low on line L of the selected device port, held for three clock cycles, enables host driver L. The device drivers of line L stay off.
- R5: Once one end owns a line, a low at the other end never enables a driver back toward the owner. The line keeps this ownership until both ends read high.
- R6: Within three cycles after the owning end returns high, the opposite driver is released. It is never driven high: all output data stays 0.
- R7: After both ends of a line read high, the line accepts a new transfer started from either end.
- R8: When both ends of an idle line go low in the same cycle, the host end wins and the device driver of that line is enabled.
- R9: A binary select value k routes the lines to device port k (value 0 is the first port). A port that is not selected has every enable at 0, and a low on such a port has no effect on the host drivers.
- R10: A change of select is applied only while every line is idle. While any line is busy, the previous port stays routed.
- R11: Each line has its own path. Activity on line L enables no driver of any other line.
- R12: The device clock output always equals the host clock input, with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | SEL_W | Port select, binary or one-hot |
| host_sdclk_i | input | 1 | Card clock from host |
| dev_sdclk_o | output | 1 | Card clock shared by all device ports |
| host_line_i | input | NLINES | Host pad input levels |
| host_line_oe_o | output | NLINES | Host pad output enables |
| host_line_o | output | NLINES | Host pad output data (always 0) |
| dev_line_i | input | NPORTS*NLINES | Device pad inputs, port p line l at bit p*NLINES+l |
| dev_line_oe_o | output | NPORTS*NLINES | Device pad output enables, same layout |
| dev_line_o | output | NPORTS*NLINES | Device pad output data (always 0) |

## Verification
The hardest case to reach from the ports is a line whose ownership is latched while the non-owning end is also pulled low. Here only the latch prevents a driver loop. The bench models each pad as a wired-AND of the block's enable, the far agent's pull-down and a pull-up. It first lets the host take a line, then has the device pull the same line low. It then releases the host while the device is still low, and checks that neither direction turns on until the device lets go. A second hard case, a select change during a transfer, is reached by moving the select while a host low is held and confirming that the routing stays put until the line drains.

// File: rtl/sdmux_pkg.sv
package sdmux_pkg;

  // Ownership of one line: nobody, host end first, device end first.
  typedef enum logic [1:0] {
    LN_IDLE = 2'd0,
    LN_HOST = 2'd1,
    LN_DEV  = 2'd2
  } ln_own_e;

endpackage

// File: rtl/sdmux_sync.sv
module sdmux_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1_q <= {W{RST_VAL}};
      stg2_q <= {W{RST_VAL}};
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;

endmodule

// File: rtl/sdmux_line_ctl.sv
module sdmux_line_ctl
  import sdmux_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    hs_i,       // synchronized host level
  input  logic    ds_i,       // synchronized selected device level
  output ln_own_e own_q_o,
  output ln_own_e own_n_o,
  output logic    to_dev_oe_o,
  output logic    to_host_oe_o
);

  ln_own_e own_q;
  ln_own_e own_n;
  logic    to_dev_oe_q;
  logic    to_host_oe_q;

  // First end seen low takes the line; host wins a tie.
  always_comb begin
    own_n = own_q;
    unique case (own_q)
      LN_IDLE: begin
        if (!hs_i)      own_n = LN_HOST;
        else if (!ds_i) own_n = LN_DEV;
      end
      LN_HOST, LN_DEV: begin
        if (hs_i && ds_i) own_n = LN_IDLE;
      end
      default: own_n = LN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q        <= LN_IDLE;
      to_dev_oe_q  <= 1'b0;
      to_host_oe_q <= 1'b0;
    end else begin
      own_q        <= own_n;
      to_dev_oe_q  <= (own_n == LN_HOST) && !hs_i;
      to_host_oe_q <= (own_n == LN_DEV) && !ds_i;
    end
  end

  assign own_q_o      = own_q;
  assign own_n_o      = own_n;
  assign to_dev_oe_o  = to_dev_oe_q;
  assign to_host_oe_o = to_host_oe_q;

endmodule

// File: rtl/sdmux_port_sel.sv
module sdmux_port_sel #(
  parameter int NPORTS     = 2,
  parameter bit SEL_ONEHOT = 1'b0,
  parameter int SEL_W      = 1,
  parameter int IDX_W      = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             allow_i,
  output logic [IDX_W-1:0] idx_o
);

  logic [IDX_W-1:0] cand;
  logic             cand_ok;
  logic [IDX_W-1:0] idx_q;

  generate
    if (SEL_ONEHOT) begin : g_onehot
      // Lowest set bit wins; all-zero keeps the current port.
      always_comb begin
        cand    = '0;
        cand_ok = |sel_i;
        for (int i = NPORTS - 1; i >= 0; i--) begin
          if (sel_i[i]) cand = IDX_W'(i);
        end
      end
    end else begin : g_binary
      always_comb begin
        cand    = IDX_W'(sel_i);
        cand_ok = (32'(sel_i) < NPORTS);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (allow_i && cand_ok) begin
      idx_q <= cand;
    end
  end

  assign idx_o = idx_q;

endmodule

// File: rtl/autodir_line_mux.sv
module autodir_line_mux
  import sdmux_pkg::*;
#(
  parameter int NPORTS     = 2,
  parameter int NLINES     = 5,
  parameter bit SEL_ONEHOT = 1'b0,
  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int SEL_W = SEL_ONEHOT ? NPORTS : IDX_W,
  localparam int DEV_W = NPORTS * NLINES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              host_sdclk_i,
  output logic              dev_sdclk_o,
  input  logic [NLINES-1:0] host_line_i,
  output logic [NLINES-1:0] host_line_oe_o,
  output logic [NLINES-1:0] host_line_o,
  input  logic [DEV_W-1:0]  dev_line_i,
  output logic [DEV_W-1:0]  dev_line_oe_o,
  output logic [DEV_W-1:0]  dev_line_o
);

  logic [NLINES-1:0] host_s;
  logic [DEV_W-1:0]  dev_s;
  logic [NLINES-1:0] dev_sel_s;
  logic [NLINES-1:0] to_dev_oe;
  logic [NLINES-1:0] to_host_oe;
  logic [NLINES-1:0] line_idle;
  logic              all_idle;
  logic [IDX_W-1:0]  act_idx_q;
  logic [NLINES-1:0] dev_by_port [NPORTS];

  // Clock passes straight through to every device port.
  assign dev_sdclk_o = host_sdclk_i;

  sdmux_sync #(.W(NLINES), .RST_VAL(1'b1)) u_host_sync (
    .clk(clk), .rst(rst), .d_i(host_line_i), .q_o(host_s)
  );

  sdmux_sync #(.W(DEV_W), .RST_VAL(1'b1)) u_dev_sync (
    .clk(clk), .rst(rst), .d_i(dev_line_i), .q_o(dev_s)
  );

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port_split
      assign dev_by_port[p] = dev_s[p*NLINES +: NLINES];
    end
  endgenerate

  assign dev_sel_s = dev_by_port[act_idx_q];

  generate
    for (genvar l = 0; l < NLINES; l++) begin : g_line
      ln_own_e own_q;
      ln_own_e own_n;

      sdmux_line_ctl u_ctl (
        .clk          (clk),
        .rst          (rst),
        .hs_i         (host_s[l]),
        .ds_i         (dev_sel_s[l]),
        .own_q_o      (own_q),
        .own_n_o      (own_n),
        .to_dev_oe_o  (to_dev_oe[l]),
        .to_host_oe_o (to_host_oe[l])
      );

      assign line_idle[l] = (own_q == LN_IDLE) && (own_n == LN_IDLE);
    end
  endgenerate

  assign all_idle = &line_idle;

  sdmux_port_sel #(
    .NPORTS(NPORTS), .SEL_ONEHOT(SEL_ONEHOT), .SEL_W(SEL_W), .IDX_W(IDX_W)
  ) u_sel (
    .clk(clk), .rst(rst), .sel_i(sel_i), .allow_i(all_idle), .idx_o(act_idx_q)
  );

  assign host_line_oe_o = to_host_oe;
  assign host_line_o    = '0;
  assign dev_line_o     = '0;

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_dev_oe
      assign dev_line_oe_o[p*NLINES +: NLINES] =
        (act_idx_q == IDX_W'(p)) ? to_dev_oe : '0;
    end
  endgenerate

endmodule

// File: rtl/sdmux_chk.sv
module sdmux_chk #(
  parameter int NPORTS = 2,
  parameter int NLINES = 5,
  parameter int IDX_W  = 1
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NLINES-1:0]        host_line_i,
  input logic [NLINES-1:0]        host_line_oe_o,
  input logic [NPORTS*NLINES-1:0] dev_line_i,
  input logic [NPORTS*NLINES-1:0] dev_line_oe_o,
  input logic [IDX_W-1:0]         act_idx
);

  logic [NLINES-1:0] dev_any;

  always_comb begin
    dev_any = '0;
    for (int p = 0; p < NPORTS; p++) begin
      dev_any = dev_any | dev_line_oe_o[p*NLINES +: NLINES];
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (host_line_oe_o == '0 && dev_line_oe_o == '0));

  // R5
  one_direction_chk: assert property (@(posedge clk) disable iff (rst)
    (host_line_oe_o & dev_any) == '0);

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (act_idx != $past(act_idx)) |->
      ($past(host_line_oe_o) == '0 && $past(dev_line_oe_o) == '0));

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_p
      // R9
      unsel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (act_idx != IDX_W'(p)) |-> (dev_line_oe_o[p*NLINES +: NLINES] == '0));
    end
    for (genvar l = 0; l < NLINES; l++) begin : g_l
      // R3
      host_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_any[l]) |-> !$past(host_line_i[l], 2));
      // R4
      dev_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(host_line_oe_o[l]) |->
          !$past(dev_line_i[32'(act_idx)*NLINES + l], 2));
    end
  endgenerate

endmodule

bind autodir_line_mux sdmux_chk #(
  .NPORTS(NPORTS), .NLINES(NLINES), .IDX_W(IDX_W)
) chk_i (
  .clk            (clk),
  .rst            (rst),
  .host_line_i    (host_line_i),
  .host_line_oe_o (host_line_oe_o),
  .dev_line_i     (dev_line_i),
  .dev_line_oe_o  (dev_line_oe_o),
  .act_idx        (act_idx_q)
);

// File: tb/autodir_line_mux_tb_top.sv
module autodir_line_mux_tb_top;

  localparam int NP = 2;
  localparam int NL = 5;
  localparam int DW = NP * NL;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel = 1'b0;
  logic          hclk = 1'b0;
  logic          dclk;
  logic [NL-1:0] h_drv = '0;   // host agent pulls low
  logic [DW-1:0] d_drv = '0;   // device agents pull low
  logic [NL-1:0] host_in, host_oe, host_out;
  logic [DW-1:0] dev_in, dev_oe, dev_out;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  // Wired-AND pads with pull-up.
  assign host_in = ~(host_oe & ~host_out) & ~h_drv;
  assign dev_in  = ~(dev_oe & ~dev_out) & ~d_drv;

  autodir_line_mux #(.NPORTS(NP), .NLINES(NL), .SEL_ONEHOT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .sel_i(sel),
    .host_sdclk_i(hclk), .dev_sdclk_o(dclk),
    .host_line_i(host_in), .host_line_oe_o(host_oe), .host_line_o(host_out),
    .dev_line_i(dev_in), .dev_line_oe_o(dev_oe), .dev_line_o(dev_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] dbit(input int p, input int l);
    return DW'(1) << (p*NL + l);
  endfunction

  task automatic t_reset();
    waitc(3);
    chk(host_oe == '0 && dev_oe == '0, "R1 oe in reset", {host_oe, dev_oe}, 0);
    rst = 1'b0;
    waitc(1);
    chk(host_oe == '0 && dev_oe == '0, "R1 oe after reset", {host_oe, dev_oe}, 0);
    waitc(6);
    chk(host_oe == '0 && dev_oe == '0, "R2 idle lines", {host_oe, dev_oe}, 0);
  endtask

  task automatic t_host_to_dev(input int l);
    h_drv[l] = 1'b1;
    waitc(4);
    chk(dev_oe == dbit(0, l), "R3 R11 device driver", dev_oe, dbit(0, l));
    chk(host_oe == '0, "R3 host driver off", host_oe, 0);
    chk(dev_out == '0 && host_out == '0, "R6 data low", {host_out, dev_out}, 0);
    h_drv[l] = 1'b0;
    waitc(4);
    chk(dev_oe == '0, "R6 release", dev_oe, 0);
    chk(dev_in[l] == 1'b1, "R6 pull-up", dev_in[l], 1);
    waitc(4);
  endtask

  task automatic t_dev_to_host(input int l);
    d_drv[l] = 1'b1;
    waitc(4);
    chk(host_oe == NL'(1) << l, "R4 R11 host driver", host_oe, NL'(1) << l);
    chk(dev_oe == '0, "R4 device drivers off", dev_oe, 0);
    d_drv[l] = 1'b0;
    waitc(4);
    chk(host_oe == '0, "R6 host release", host_oe, 0);
    waitc(4);
  endtask

  task automatic t_latch();
    h_drv[0] = 1'b1;
    waitc(4);
    d_drv[0] = 1'b1;
    waitc(4);
    chk(host_oe == '0, "R5 no back drive", host_oe, 0);
    h_drv[0] = 1'b0;
    waitc(4);
    chk(dev_oe == '0, "R6 owner gone", dev_oe, 0);
    chk(host_oe == '0, "R5 latched while device low", host_oe, 0);
    d_drv[0] = 1'b0;
    waitc(6);
    d_drv[0] = 1'b1;
    waitc(4);
    chk(host_oe == NL'(1), "R7 reverse after idle", host_oe, 1);
    d_drv[0] = 1'b0;
    waitc(8);
  endtask

  task automatic t_simul();
    h_drv[2] = 1'b1;
    d_drv[2] = 1'b1;
    waitc(4);
    chk(dev_oe == dbit(0, 2) && host_oe == '0, "R8 host wins tie",
        {host_oe, dev_oe}, dbit(0, 2));
    h_drv[2] = 1'b0;
    d_drv[2] = 1'b0;
    waitc(8);
  endtask

  task automatic t_select();
    sel = 1'b1;
    waitc(3);
    h_drv[3] = 1'b1;
    waitc(4);
    chk(dev_oe == dbit(1, 3), "R9 routed to port 1", dev_oe, dbit(1, 3));
    h_drv[3] = 1'b0;
    waitc(8);
    d_drv[0*NL + 1] = 1'b1;
    waitc(4);
    chk(host_oe == '0 && dev_oe == '0, "R9 unselected ignored",
        {host_oe, dev_oe}, 0);
    d_drv[0*NL + 1] = 1'b0;
    waitc(4);
    sel = 1'b0;
    waitc(3);
  endtask

  task automatic t_defer();
    h_drv[1] = 1'b1;
    waitc(4);
    sel = 1'b1;
    waitc(4);
    chk(dev_oe == dbit(0, 1), "R10 held on busy line", dev_oe, dbit(0, 1));
    h_drv[1] = 1'b0;
    waitc(10);
    h_drv[1] = 1'b1;
    waitc(4);
    chk(dev_oe == dbit(1, 1), "R10 applied when idle", dev_oe, dbit(1, 1));
    h_drv[1] = 1'b0;
    waitc(8);
    sel = 1'b0;
    waitc(3);
  endtask

  task automatic t_clock();
    hclk = 1'b1;
    #1;
    chk(dclk == 1'b1, "R12 clock high", dclk, 1);
    hclk = 1'b0;
    #1;
    chk(dclk == 1'b0, "R12 clock low", dclk, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_host_to_dev(0);
    t_host_to_dev(4);
    t_dev_to_host(1);
    t_dev_to_host(3);
    t_latch();
    t_simul();
    t_select();
    t_defer();
    t_clock();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule